// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block turns a wide vector of request lines into the binary index of the highest-numbered line that is set. It is built from identical narrow slices. Each slice reports two status flags. One says that the slice holds an active request. The other hands the enable on to the next slice down when the slice has nothing to report. Chaining the slices through that hand-off gives each group strict precedence over every group below it.

The default build has 32 request lines in four slices of eight. The external enable enters the slice for lines 31..24 and ripples down to the slice for lines 7..0. The merged result is a 5-bit index, a valid flag and an enable-out from the bottom slice, so a further stage of the same kind can hang below it. The logic is purely combinational.

Top module: `cascade_prio_enc`

## Requirements
- R1: With enable high and at least one request set, the index output equals the position of the highest-numbered set request line, whatever the lines below it hold.
- R2: The valid output is high exactly when enable is high and at least one request line is set.
- R3: The enable-out output is high exactly when enable is high and no request line is set.
- R4: With enable low, the index, valid and enable-out outputs are all zero for every request pattern.
- R5: With enable high and all request lines clear, the index is zero, valid is zero and enable-out is one.
- R6: Index bits 4..3 name the group that holds the winning request: 3 for lines 31..24, 2 for 23..16, 1 for 15..8 and 0 for 7..0. Bits 2..0 give the line's position within that group.
- R7: A request in a lower group has no effect on the index when a higher group holds any request.
- R8: Valid and enable-out are never high together. When enable is high, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Enable into the highest-priority group |
| req_i | input | 32 | Request lines; a higher number wins |
| idx_o | output | 5 | Index of the winning request line |
| valid_o | output | 1 | At least one request is active while enabled |
| en_out_o | output | 1 | Enable passed on to a lower stage; no request active |

## Verification
The case that matters is two groups holding requests at the same time. The upper slice then raises its group flag while the lower slice would also produce an index if it were enabled. The bench provokes this with patterns that set bits in two or more slices at once, such as lines 24 and 0, or lines 28 and 4. It judges the result against a reference that scans from line 31 downward. The index must come from the upper group alone, with the lower group's bits absent from the low index field. Random multi-bit patterns repeat this contention across every pair of groups.

// File: rtl/pe_pkg.sv
package pe_pkg;

    localparam int unsigned DEF_SLICE_W    = 8;
    localparam int unsigned DEF_NUM_SLICES = 4;

    // Per-slice status flags passed to the merge stage.
    typedef struct packed {
        logic grp_sel;   // enabled and holding a request
        logic en_out;    // enabled and holding none
    } pe_stat_t;

endpackage

// File: rtl/pe_slice.sv
module pe_slice
    import pe_pkg::*;
#(
    parameter int unsigned SLICE_W = DEF_SLICE_W,
    localparam int unsigned IW     = $clog2(SLICE_W)
) (
    input  logic               en_i,
    input  logic [SLICE_W-1:0] req_i,
    output logic [IW-1:0]      idx_o,
    output pe_stat_t           stat_o
);

    typedef struct packed {
        logic [IW-1:0] idx;
        pe_stat_t      stat;
    } slice_res_t;

    slice_res_t res_d;

    always_comb begin
        res_d = '0;
        // Ascending scan: the last hit is the highest set line.
        for (int i = 0; i < int'(SLICE_W); i++) begin
            if (req_i[i]) begin
                res_d.idx = IW'(i);
            end
        end
        res_d.stat.grp_sel = en_i & (|req_i);
        res_d.stat.en_out  = en_i & ~(|req_i);
        if (!en_i) begin
            res_d.idx = '0;
        end
    end

    assign idx_o  = res_d.idx;
    assign stat_o = res_d.stat;

endmodule

// File: rtl/pe_merge.sv
module pe_merge
    import pe_pkg::*;
#(
    parameter int unsigned NUM_SLICES = DEF_NUM_SLICES,
    parameter int unsigned IW         = 3,
    localparam int unsigned GW        = $clog2(NUM_SLICES)
) (
    input  pe_stat_t [NUM_SLICES-1:0]         stat_i,
    input  logic     [NUM_SLICES-1:0][IW-1:0] idx_i,
    output logic     [GW+IW-1:0]              idx_o,
    output logic                              valid_o,
    output logic                              en_out_o
);

    typedef struct packed {
        logic [GW-1:0] grp;
        logic [IW-1:0] low;
        logic          valid;
    } merge_res_t;

    merge_res_t res_d;

    always_comb begin
        res_d = '0;
        for (int g = 0; g < int'(NUM_SLICES); g++) begin
            // At most one slice is selected, so the code and the index both OR in safely.
            if (stat_i[g].grp_sel) begin
                res_d.grp = GW'(g);
            end
            res_d.low   = res_d.low | idx_i[g];
            res_d.valid = res_d.valid | stat_i[g].grp_sel;
        end
    end

    assign idx_o    = {res_d.grp, res_d.low};
    assign valid_o  = res_d.valid;
    assign en_out_o = stat_i[0].en_out;

endmodule

// File: rtl/cascade_prio_enc.sv
module cascade_prio_enc
    import pe_pkg::*;
#(
    parameter int unsigned SLICE_W    = DEF_SLICE_W,
    parameter int unsigned NUM_SLICES = DEF_NUM_SLICES,
    localparam int unsigned N_REQ     = SLICE_W * NUM_SLICES,
    localparam int unsigned IW        = $clog2(SLICE_W),
    localparam int unsigned OW        = $clog2(N_REQ)
) (
    input  logic             en_i,
    input  logic [N_REQ-1:0] req_i,
    output logic [OW-1:0]    idx_o,
    output logic             valid_o,
    output logic             en_out_o
);

    logic     [NUM_SLICES:0]           en_chain;
    pe_stat_t [NUM_SLICES-1:0]         stat;
    logic     [NUM_SLICES-1:0][IW-1:0] sl_idx;

    assign en_chain[NUM_SLICES] = en_i;

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        pe_slice #(.SLICE_W(SLICE_W)) u_slice (
            .en_i   (en_chain[g+1]),
            .req_i  (req_i[g*SLICE_W +: SLICE_W]),
            .idx_o  (sl_idx[g]),
            .stat_o (stat[g])
        );
        assign en_chain[g] = stat[g].en_out;
    end

    pe_merge #(.NUM_SLICES(NUM_SLICES), .IW(IW)) u_merge (
        .stat_i   (stat),
        .idx_i    (sl_idx),
        .idx_o    (idx_o),
        .valid_o  (valid_o),
        .en_out_o (en_out_o)
    );

endmodule

// File: rtl/cascade_prio_enc_chk.sv
module cascade_prio_enc_chk #(
    parameter int unsigned N_REQ = 32,
    parameter int unsigned OW    = 5
) (
    input logic             en_i,
    input logic [N_REQ-1:0] req_i,
    input logic [OW-1:0]    idx_o,
    input logic             valid_o,
    input logic             en_out_o
);

    always_comb begin
        // R1: the winning line is set and nothing above it is set
        if (valid_o) begin
            a_r1_winner_set: assert (req_i[idx_o]);
            a_r1_none_above: assert ((req_i >> idx_o) == N_REQ'(1));
        end
        a_r2_valid: assert (valid_o == (en_i && (|req_i)));
        a_r3_en_out: assert (en_out_o == (en_i && !(|req_i)));
        if (!en_i) begin
            a_r4_disabled_zero: assert (idx_o == '0 && !valid_o && !en_out_o);
        end
        if (en_i && req_i == '0) begin
            a_r5_idle_idx_zero: assert (idx_o == '0);
        end
        a_r8_flags_exclusive: assert ($onehot0({valid_o, en_out_o}));
        if (en_i) begin
            a_r8_one_flag: assert ($countones({valid_o, en_out_o}) == 1);
        end
    end

endmodule

bind cascade_prio_enc cascade_prio_enc_chk #(.N_REQ(N_REQ), .OW(OW)) u_chk (
    .en_i     (en_i),
    .req_i    (req_i),
    .idx_o    (idx_o),
    .valid_o  (valid_o),
    .en_out_o (en_out_o)
);

// File: tb/cascade_prio_enc_bench.sv
module cascade_prio_enc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en;
    logic [31:0] req;
    logic [4:0]  idx;
    logic        valid;
    logic        en_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    cascade_prio_enc u_cascade_prio_enc (
        .en_i     (en),
        .req_i    (req),
        .idx_o    (idx),
        .valid_o  (valid),
        .en_out_o (en_out)
    );

    // Vector layout: {en, req[31:0], idx[4:0], valid, en_out}
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 32'h0000_0000, 5'd0,  1'b0, 1'b1},
        {1'b0, 32'hFFFF_FFFF, 5'd0,  1'b0, 1'b0},
        {1'b1, 32'h0000_0001, 5'd0,  1'b1, 1'b0},
        {1'b1, 32'h8000_0000, 5'd31, 1'b1, 1'b0},
        {1'b1, 32'hFFFF_FFFF, 5'd31, 1'b1, 1'b0},
        {1'b1, 32'h0100_0001, 5'd24, 1'b1, 1'b0},
        {1'b1, 32'h00FF_0000, 5'd23, 1'b1, 1'b0},
        {1'b1, 32'h0000_0180, 5'd8,  1'b1, 1'b0},
        {1'b1, 32'h0000_007F, 5'd6,  1'b1, 1'b0},
        {1'b1, 32'h1000_0010, 5'd28, 1'b1, 1'b0},
        {1'b0, 32'h0000_0001, 5'd0,  1'b0, 1'b0},
        {1'b1, 32'h0001_0100, 5'd16, 1'b1, 1'b0}
    };

    function automatic logic [4:0] ref_idx(input logic [31:0] r);
        for (int i = 31; i >= 0; i--) begin
            if (r[i]) return 5'(i);
        end
        return 5'd0;
    endfunction

    task automatic check(input string tag, input logic e, input logic [31:0] r,
                         input logic [4:0] x_idx, input logic x_v, input logic x_eo);
        n_chk++;
        if (idx !== x_idx || valid !== x_v || en_out !== x_eo) begin
            n_fail++;
            $display("FAIL %s en=%b req=%h actual idx=%0d v=%b eo=%b expected idx=%0d v=%b eo=%b",
                     tag, e, r, idx, valid, en_out, x_idx, x_v, x_eo);
        end
    endtask

    task automatic apply(input logic e, input logic [31:0] r);
        @(posedge clk);
        en  = e;
        req = r;
        @(negedge clk);
    endtask

    task automatic ref_check(input string tag, input logic e, input logic [31:0] r);
        apply(e, r);
        check(tag, e, r, e ? ref_idx(r) : 5'd0, e & (|r), e & ~(|r));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        en  = 1'b0;
        req = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset state", en, req, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][39], VEC[v][38:7]);
            check("R1/R2/R3 table", VEC[v][39], VEC[v][38:7],
                  VEC[v][6:2], VEC[v][1], VEC[v][0]);
        end

        // R6: every single line maps to group in bits 4..3, position in 2..0
        for (int b = 0; b < 32; b++) begin
            apply(1'b1, 32'd1 << b);
            check("R6 single line", 1'b1, 32'd1 << b, {2'(b / 8), 3'(b % 8)}, 1'b1, 1'b0);
        end

        // R7: lower groups full of requests never disturb a higher winner
        for (int g = 1; g < 4; g++) begin
            apply(1'b1, (32'd1 << (g * 8)) | ((32'd1 << (g * 8)) - 1));
            check("R7 lower ignored", 1'b1, req, 5'(g * 8), 1'b1, 1'b0);
        end

        // R5: enabled, no requests
        apply(1'b1, 32'h0);
        check("R5 idle", 1'b1, 32'h0, 5'd0, 1'b0, 1'b1);

        // R4: disabled with varied patterns
        for (int k = 0; k < 8; k++) begin
            ref_check("R4 disabled", 1'b0, $urandom());
        end

        // R1 R2 R3 R8: random multi-bit patterns against the reference scan
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r;
            r = $urandom() & $urandom();
            if (k % 3 == 0) r = r & 32'h0000_FFFF;
            ref_check("R1/R8 random", 1'b1, r);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule